// File: doc/BRIEF.md
# Five-Bit Bidirectional I/O Port

This block is a small memory-mapped general-purpose I/O port of the kind found beside an 8-bit processor core. It has a five-bit output latch and a five-bit direction register, and both are loaded from the core's internal byte-wide data bus. Toward the pad ring it drives a value and an output enable for each pin. It also samples the pin levels back through a two-stage synchronizer.

Pins 3 down to 0 drive both high and low. Pin 4 can only pull low, and its synchronized level also feeds a timer as an external clock whatever its direction. A read of the data register returns the synchronized pin levels, not the latch. For this reason the single-cycle bit set and bit clear commands rebuild the whole latch from what the pins show. A pin that is configured as an input, or that is held by something outside, can therefore silently change its latch bit.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, every direction bit is 1, the output latch is 0, and every `pin_oe` bit is low.
- R2: `cmd`=01 (byte write) with `addr`=0 loads `wdata[4:0]` into the output latch and leaves the direction register unchanged. `wdata[7:5]` has no effect.
- R3: `cmd`=01 with `addr`=1 loads `wdata[4:0]` into the direction register. On the next cycle, pins 3..0 drive `pin_oe`=~direction and `pin_out`=latch.
- R4: Pin 4 is open-drain. `pin_out[4]` is always 0, and `pin_oe[4]` is high only when direction bit 4 is 0 and latch bit 4 is 0. Otherwise the pin floats and reads the external level.
- R5: A read with `rd_addr`=0 returns the synchronized pin levels in bits 4:0. A read with `rd_addr`=1 returns the direction register. Bits 7:5 of `rdata` are always 0.
- R6: A change on `pin_in` appears on `rdata` and `tmr_clk` after exactly two rising clock edges.
- R7: `tmr_clk` equals the synchronized level of pin 4, whatever the value of direction bit 4.
- R8: `cmd`=10 (set) or 11 (clear) with `addr`=0 takes the synchronized pin levels, forces bit `bit_idx` to 1 or 0, and writes all five bits to the latch in one cycle.
- R9: `cmd`=10 or 11 with `addr`=1 sets or clears bit `bit_idx` of the direction register and keeps its other bits.
- R10: A `bit_idx` of 5, 6 or 7 changes no bit. On `addr`=0 the latch is still rewritten from the synchronized pins. On `addr`=1 the direction register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 00 idle, 01 byte write, 10 bit set, 11 bit clear |
| addr | input | 1 | Command target: 0 data latch, 1 direction register |
| wdata | input | 8 | Byte-write data |
| bit_idx | input | 3 | Bit index for set and clear |
| rd_addr | input | 1 | Read select: 0 pin levels, 1 direction |
| rdata | output | 8 | Read data |
| pin_in | input | 5 | Pad levels sampled from the pins |
| pin_out | output | 5 | Value to drive on each pad |
| pin_oe | output | 5 | Output enable for each pad |
| tmr_clk | output | 1 | Synchronized pin 4 level toward the timer |

## Verification
The assertions assume that `cmd`, `addr`, `wdata` and `bit_idx` hold steady around each rising edge. They also assume that `pin_in` is the pad's resolved level, so it follows `pin_out` wherever `pin_oe` is high. The bench keeps to this by changing inputs just after a rising edge. It models the pads itself: a driven pin reads its own output, and a floating or input pin reads an external level. Before any bit command or any read of the pin levels, it waits three edges after any pin or latch change, so the synchronized value has settled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_BSET  = 2'b10,
    CMD_BCLR  = 2'b11
  } gpio_cmd_e;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_DIR  = 1'b1;

  // Force one bit of a bus word; an index at or above width leaves it alone.
  function automatic logic [BUS_W-1:0] rmw_bit(input logic [BUS_W-1:0] base,
                                               input logic [IDX_W-1:0] idx,
                                               input logic val,
                                               input int unsigned width);
    logic [BUS_W-1:0] r;
    r = base;
    if (32'(idx) < width) r[idx] = val;
    return r;
  endfunction

  // Output enable of one pad: push-pull drives when configured as output,
  // open-drain only when configured as output and pulling low.
  function automatic logic pad_enable(input logic dir_bit, input logic lat_bit,
                                      input logic open_drain);
    return open_drain ? (~dir_bit & ~lat_bit) : ~dir_bit;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned PORT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic              addr,
  input  logic [PORT_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [PORT_W-1:0] pins_sync,
  output logic [PORT_W-1:0] lat_q,
  output logic [PORT_W-1:0] dir_q,
  output logic              data_upd,
  output logic              dir_upd,
  output logic              idx_in_range
);
  gpio_cmd_e        op;
  logic             is_bitop;
  logic             bit_val;
  logic [BUS_W-1:0] data_mod;
  logic [BUS_W-1:0] dir_mod;
  logic [PORT_W-1:0] lat_nxt;
  logic [PORT_W-1:0] dir_nxt;

  assign op           = gpio_cmd_e'(cmd);
  assign is_bitop     = (op == CMD_BSET) || (op == CMD_BCLR);
  assign bit_val      = (op == CMD_BSET);
  assign idx_in_range = 32'(bit_idx) < PORT_W;
  assign data_upd     = (op != CMD_IDLE) && (addr == SEL_DATA);
  assign dir_upd      = (op != CMD_IDLE) && (addr == SEL_DIR);

  // Data bit ops start from the pins, direction bit ops from the register.
  assign data_mod = rmw_bit(BUS_W'(pins_sync), bit_idx, bit_val, PORT_W);
  assign dir_mod  = rmw_bit(BUS_W'(dir_q), bit_idx, bit_val, PORT_W);

  always_comb begin
    lat_nxt = lat_q;
    dir_nxt = dir_q;
    if (data_upd) lat_nxt = is_bitop ? data_mod[PORT_W-1:0] : wr_val;
    if (dir_upd)  dir_nxt = is_bitop ? dir_mod[PORT_W-1:0] : wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      lat_q <= lat_nxt;
      dir_q <= dir_nxt;
    end
  end

  AST_DATA_WR_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    data_upd |=> $stable(dir_q)); // R2

  AST_DATA_BSET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_upd && op == CMD_BSET && idx_in_range) |=> lat_q[$past(bit_idx)]); // R8

  AST_DIR_BCLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_upd && op == CMD_BCLR && idx_in_range) |=> !dir_q[$past(bit_idx)]); // R9

  AST_DIR_OOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_upd && is_bitop && !idx_in_range) |=> $stable(dir_q)); // R10
endmodule

// File: rtl/gpio_pads.sv
module gpio_pads
  import gpio_pkg::*;
#(
  parameter int unsigned      PORT_W  = 5,
  parameter logic [PORT_W-1:0] OD_MASK = {1'b1, {(PORT_W-1){1'b0}}}
) (
  input  logic [PORT_W-1:0] lat_q,
  input  logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pad
      if (OD_MASK[i]) begin : g_od
        assign pin_out[i] = 1'b0;
        assign pin_oe[i]  = pad_enable(dir_q[i], lat_q[i], 1'b1);
      end else begin : g_pp
        assign pin_out[i] = lat_q[i];
        assign pin_oe[i]  = pad_enable(dir_q[i], lat_q[i], 1'b0);
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned       PORT_W   = 5,
  parameter int unsigned       SYNC_N   = 2,
  parameter int unsigned       TMR_BIT  = 4,
  parameter logic [PORT_W-1:0] OD_MASK  = {1'b1, {(PORT_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic              addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              rd_addr,
  output logic [BUS_W-1:0]  rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              tmr_clk
);
  localparam logic [PORT_W-1:0] PP_MASK = ~OD_MASK;

  logic [PORT_W-1:0] pins_sync;
  logic [PORT_W-1:0] lat_q;
  logic [PORT_W-1:0] dir_q;
  logic              data_upd;
  logic              dir_upd;
  logic              idx_in_range;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[BUS_W-1:PORT_W];

  gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pins_sync));

  gpio_regs #(.PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr),
    .wr_val(wdata[PORT_W-1:0]), .bit_idx(bit_idx), .pins_sync(pins_sync),
    .lat_q(lat_q), .dir_q(dir_q), .data_upd(data_upd), .dir_upd(dir_upd),
    .idx_in_range(idx_in_range));

  gpio_pads #(.PORT_W(PORT_W), .OD_MASK(OD_MASK)) u_pads (
    .lat_q(lat_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe));

  assign tmr_clk = pins_sync[TMR_BIT];
  assign rdata   = (rd_addr == SEL_DATA) ? BUS_W'(pins_sync) : BUS_W'(dir_q);

  // Cycles since reset, saturating; gates the two-deep look into the past.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always_comb begin
    AST_RD_HIGH_ZERO: assert (rdata[BUS_W-1:PORT_W] == '0); // R5
  end

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_upd && gpio_cmd_e'(cmd) == CMD_WRITE) |=>
      ((pin_oe & PP_MASK) == (~$past(wdata[PORT_W-1:0]) & PP_MASK))); // R3

  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_upd && gpio_cmd_e'(cmd) == CMD_WRITE && wdata[TMR_BIT]) |=>
      !pin_oe[TMR_BIT]); // R4

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !((pin_oe & OD_MASK & pin_out) != '0)); // R4

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (tmr_clk == $past(pin_in[TMR_BIT], 2))); // R6

  AST_TMR_TAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == SEL_DATA) |-> (tmr_clk == rdata[TMR_BIT])); // R7
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_P = 10;
  localparam int W = 5;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] cmd = 2'b00;
  logic       addr = 0;
  logic [7:0] wdata = 8'h00;
  logic [2:0] bit_idx = 3'd0;
  logic       rd_addr = 0;
  logic [7:0] rdata;
  logic [W-1:0] pin_in, pin_out, pin_oe;
  logic       tmr_clk;
  logic [W-1:0] ext = 5'b01010;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_port uut (.clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
    .bit_idx(bit_idx), .rd_addr(rd_addr), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tmr_clk(tmr_clk));

  // Pad model: a driven pad shows its own output, otherwise the outside level.
  for (genvar i = 0; i < W; i++) begin : g_padm
    assign pin_in[i] = pin_oe[i] ? pin_out[i] : ext[i];
  end

  // Bench-side model of the registers.
  logic [W-1:0] m_lat = '0;
  logic [W-1:0] m_dir = '1;

  function automatic logic [W-1:0] m_pins();
    logic [W-1:0] p;
    for (int i = 0; i < W; i++) begin
      if (m_dir[i]) p[i] = ext[i];
      else if (i == 4) p[i] = m_lat[i] ? ext[i] : 1'b0;
      else p[i] = m_lat[i];
    end
    return p;
  endfunction

  function automatic logic [W-1:0] m_oe();
    logic [W-1:0] e;
    for (int i = 0; i < W; i++) e[i] = (i == 4) ? (!m_dir[i] && !m_lat[i]) : !m_dir[i];
    return e;
  endfunction

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  // Monitor: compare queued expectations against the outputs at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = 8'(pin_out);
        2: act = 8'(pin_oe);
        default: act = 8'(tmr_clk);
      endcase
      checks++;
      if (act !== it.exp) begin
        errs++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(input string tag, input int kind, input logic [7:0] e);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    q.push_back(it);
  endtask

  task automatic check_rd(input string tag, input logic a, input logic [7:0] e);
    rd_addr = a;
    expect_item(tag, 0, e);
    @(negedge clk); #1;
  endtask

  task automatic check_pads(input string tag);
    expect_item(tag, 1, 8'(m_lat & 5'b01111));
    expect_item(tag, 2, 8'(m_oe()));
    @(negedge clk); #1;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Driver: apply one command for one cycle and update the model.
  task automatic do_cmd(input logic [1:0] c, input logic a, input logic [7:0] d,
                        input logic [2:0] idx);
    logic [W-1:0] base;
    @(posedge clk); #1;
    cmd = c; addr = a; wdata = d; bit_idx = idx;
    base = a ? m_dir : m_pins();
    @(posedge clk); #1;
    cmd = 2'b00;
    if (c == 2'b01) begin
      if (a) m_dir = d[W-1:0]; else m_lat = d[W-1:0];
    end else if (c != 2'b00) begin
      if (idx < 3'(W)) base[idx] = (c == 2'b10);
      if (a) m_dir = base; else m_lat = base;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_rd("R1 dir reset", 1'b1, 8'h1F);
    check_pads("R1 pads reset");
    rst_n = 1;
    settle();
    check_rd("R5 pins read after reset", 1'b0, 8'(m_pins()));

    do_cmd(2'b01, 1'b0, 8'hF5, 3'd0);
    check_pads("R2 latch load, inputs only");
    check_rd("R2 dir untouched", 1'b1, 8'h1F);
    settle();
    check_rd("R2 pins unchanged by latch", 1'b0, 8'(m_pins()));

    do_cmd(2'b01, 1'b1, 8'hE0, 3'd0);
    check_rd("R3 dir write", 1'b1, 8'h00);
    check_pads("R3 push-pull drive");
    settle();
    check_rd("R4 floating od pin reads outside", 1'b0, 8'(m_pins()));

    @(posedge clk); #1;
    ext[4] = 1'b1;
    @(posedge clk); #1;
    expect_item("R6 one edge no change", 3, 8'h00);
    @(negedge clk); #1;
    @(posedge clk); #1;
    expect_item("R6 R7 two edges tap", 3, 8'h01);
    @(negedge clk); #1;
    settle();
    check_rd("R5 pins high od", 1'b0, 8'(m_pins()));

    do_cmd(2'b11, 1'b0, 8'h00, 3'd4);
    check_pads("R4 od pulls low");
    settle();
    check_rd("R8 R4 od low read", 1'b0, 8'(m_pins()));
    expect_item("R7 tap follows od low", 3, 8'(m_pins() >> 4));
    @(negedge clk); #1;

    do_cmd(2'b01, 1'b1, 8'h01, 3'd0);
    ext[0] = 1'b0;
    settle();
    do_cmd(2'b10, 1'b0, 8'h00, 3'd3);
    check_pads("R8 set rebuilds from pins");

    ext[0] = 1'b1;
    settle();
    do_cmd(2'b10, 1'b0, 8'h00, 3'd6);
    check_pads("R10 out-of-range data rewrite");
    settle();
    check_rd("R10 R5 read high zero", 1'b0, 8'(m_pins()));

    do_cmd(2'b10, 1'b1, 8'h00, 3'd4);
    do_cmd(2'b11, 1'b1, 8'h00, 3'd0);
    check_rd("R9 dir bit ops", 1'b1, 8'(m_dir));
    check_pads("R9 pads after dir ops");

    do_cmd(2'b11, 1'b1, 8'h00, 3'd7);
    check_rd("R10 dir out-of-range", 1'b1, 8'(m_dir));

    do_cmd(2'b01, 1'b1, 8'hFF, 3'd0);
    check_rd("R3 R5 dir upper bits", 1'b1, 8'h1F);
    check_pads("R3 all inputs");
    settle();
    expect_item("R7 tap with input dir", 3, 8'(ext[4]));
    @(negedge clk); #1;

    @(posedge clk); #1;
    rst_n = 0;
    m_lat = '0; m_dir = '1;
    @(negedge clk); #1;
    check_pads("R1 reset mid-run");
    check_rd("R1 dir mid-run", 1'b1, 8'h1F);
    rst_n = 1;
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule